// File: doc/BRIEF.md
# Serial ADC Register Access Port

This block sits behind the serial pins of a converter and handles register traffic. A host lowers an active-low frame strobe, clocks 16 bits in on a serial clock, and raises the strobe again. The two leading bits of each frame name a target and the other fourteen bits are its payload. The payload is written to the target only after the sixteenth bit has arrived. A control word held inside the block is written only through this path and is never read back. Two bits of the control word choose what the read side sends out. Each frame shifts back either the conversion result, a status word, the calibration word or an internal test word. That choice stays in force until the host writes the control word again.

The block takes the serial inputs on its own clock. It passes them through a synchronizer and finds the serial-clock edges from the synchronized copies. The master samples the output on rising edges, and the block moves its output on falling edges. The conversion result, the status word and the calibration word arrive on parallel inputs. A calibration write leaves the block as a one-cycle strobe that carries its payload.

Top module: `serial_adc_regport`

## Requirements
- R1: A frame is 16 bits, MSB first. Bits 15:14 of the frame are the target code and bits 13:0 are the payload. The payload is applied in the system cycle after the sixteenth rising serial-clock edge.
- R2: If the strobe rises before sixteen bits have arrived, the frame writes nothing and the bit counter returns to zero. The next full frame then decodes correctly.
- R3: Target code 11 writes the payload into the 14-bit control word `ctrl_o`. The control word is all zeros after reset, and no other code changes it.
- R4: The read-select field `rd_sel_o` is control bits 7:6. Its reset value, 00, returns the conversion result as two zero bits followed by the 14 data bits, MSB first.
- R5: Read-select 11 returns the 16-bit `status_i` unchanged.
- R6: Read-select 10 returns two zero bits followed by `cal_data_i`.
- R7: Target code 01 writes a 14-bit test word. Read-select 01 returns that word behind two zero bits.
- R8: Target code 10 produces exactly one `cal_wr_o` pulse, one cycle long, with the payload on `cal_wdata_o`. Target code 00 writes nothing and produces no strobe.
- R9: The read selection applies to every later frame until the control word is written again.
- R10: When the strobe is high, `sdo_oe_o` is 0 and `sdo_o` is 0. Inside a frame, `sdo_o` moves only after falling serial-clock edges and stays put across rising edges.
- R11: Serial-clock edges after the sixteenth edge of a frame are ignored. They cause no second write.
- R12: The word a frame sends out is taken when the frame starts. A control write therefore changes the read source from the following frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_n_i | input | 1 | Frame strobe, active low |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data in |
| conv_data_i | input | 14 | Conversion result |
| status_i | input | 16 | Status word |
| cal_data_i | input | 14 | Calibration word for read-back |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the sdo pad |
| ctrl_o | output | 14 | Control word |
| rd_sel_o | output | 2 | Read-select field |
| cal_wr_o | output | 1 | Calibration write strobe |
| cal_wdata_o | output | 14 | Calibration write payload |

## Verification
The bench checks that a control write does not change the word sent out in the same frame. A design that samples the select too late would return the new source one frame early. It checks that a frame cut short after seven bits leaves the control word untouched and that the next frame decodes properly. A counter that is not cleared would misalign that next frame and corrupt a register. It sends a frame with twenty edges, which would expose a second commit. It compares the output just before and just after each rising edge, which would catch output that moves on the wrong edge. It also repeats reads under a fixed select while the status input changes, which would catch a select that falls back to its default.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int unsigned FRAME_W  = 16;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned DATA_W   = FRAME_W - ADDR_W;
  localparam int unsigned CNT_W    = $clog2(FRAME_W + 1);
  localparam int unsigned RSEL_LSB = 6;

  typedef enum logic [ADDR_W-1:0] {
    WA_NOP  = 2'b00,
    WA_TEST = 2'b01,
    WA_CAL  = 2'b10,
    WA_CTRL = 2'b11
  } wr_addr_e;

  typedef enum logic [1:0] {
    RS_CONV = 2'b00,
    RS_TEST = 2'b01,
    RS_CAL  = 2'b10,
    RS_STAT = 2'b11
  } rd_sel_e;
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[g] <= RST_VAL;
      else if (g == 0) st_q[g] <= d_i;
      else st_q[g] <= st_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/sadc_rx.sv
module sadc_rx
  import sadc_pkg::*;
#(
  parameter int unsigned FW = FRAME_W,
  localparam int unsigned CW = $clog2(FW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_act_i,
  input  logic          rise_i,
  input  logic          sdi_i,
  output logic          commit_o,
  output logic [FW-1:0] word_o,
  output logic [CW-1:0] bit_cnt_o
);
  logic [FW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic          take;

  assign take = frame_act_i && rise_i && (cnt_q < CW'(FW));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      commit_o <= 1'b0;
      word_o   <= '0;
    end else begin
      commit_o <= 1'b0;
      if (!frame_act_i) begin
        cnt_q <= '0;
      end else if (take) begin
        sh_q  <= {sh_q[FW-2:0], sdi_i};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(FW - 1)) begin
          commit_o <= 1'b1;
          word_o   <= {sh_q[FW-2:0], sdi_i};
        end
      end
    end
  end

  assign bit_cnt_o = cnt_q;
endmodule

// File: rtl/sadc_regs.sv
module sadc_regs
  import sadc_pkg::*;
#(
  parameter int unsigned FW = FRAME_W,
  parameter int unsigned AW = ADDR_W,
  localparam int unsigned DW = FW - AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          commit_i,
  input  logic [FW-1:0] word_i,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] test_o,
  output logic          cal_wr_o,
  output logic [DW-1:0] cal_wdata_o
);
  wr_addr_e      addr;
  logic [DW-1:0] data;

  assign addr = wr_addr_e'(word_i[FW-1 -: AW]);
  assign data = word_i[DW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o      <= '0;
      test_o      <= '0;
      cal_wr_o    <= 1'b0;
      cal_wdata_o <= '0;
    end else begin
      cal_wr_o <= 1'b0;
      if (commit_i) begin
        unique case (addr)
          WA_CTRL: ctrl_o <= data;
          WA_TEST: test_o <= data;
          WA_CAL: begin
            cal_wr_o    <= 1'b1;
            cal_wdata_o <= data;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sadc_tx.sv
module sadc_tx
  import sadc_pkg::*;
#(
  parameter int unsigned FW = FRAME_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          frame_act_i,
  input  logic          fall_i,
  input  logic [FW-1:0] load_i,
  output logic          bit_o
);
  logic [FW-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else if (start_i) sh_q <= load_i;
    else if (frame_act_i && fall_i) sh_q <= {sh_q[FW-2:0], 1'b0};
  end

  assign bit_o = sh_q[FW-1];
endmodule

// File: rtl/serial_adc_regport.sv
module serial_adc_regport
  import sadc_pkg::*;
#(
  parameter int unsigned FW       = FRAME_W,
  parameter int unsigned AW       = ADDR_W,
  parameter int unsigned SYNC_STG = 2,
  localparam int unsigned DW = FW - AW,
  localparam int unsigned CW = $clog2(FW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_n_i,
  input  logic          sclk_i,
  input  logic          sdi_i,
  input  logic [DW-1:0] conv_data_i,
  input  logic [FW-1:0] status_i,
  input  logic [DW-1:0] cal_data_i,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  output logic [DW-1:0] ctrl_o,
  output logic [1:0]    rd_sel_o,
  output logic          cal_wr_o,
  output logic [DW-1:0] cal_wdata_o
);
  localparam logic [2:0] SYNC_RST = 3'b100;

  logic [2:0]    s;
  logic          frame_act, sclk_s, sdi_s;
  logic          sclk_prev_q, frame_prev_q;
  logic          sclk_rise, sclk_fall, frame_start;
  logic          commit;
  logic [FW-1:0] word;
  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] test_w;
  logic [FW-1:0] rd_word;
  logic          tx_bit;

  sadc_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({frame_n_i, sclk_i, sdi_i}),
    .q_o   (s)
  );

  assign frame_act = ~s[2];
  assign sclk_s    = s[1];
  assign sdi_s     = s[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q  <= 1'b0;
      frame_prev_q <= 1'b0;
    end else begin
      sclk_prev_q  <= sclk_s;
      frame_prev_q <= frame_act;
    end
  end

  assign sclk_rise   = sclk_s & ~sclk_prev_q;
  assign sclk_fall   = ~sclk_s & sclk_prev_q;
  assign frame_start = frame_act & ~frame_prev_q;

  sadc_rx #(.FW(FW)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_act_i(frame_act),
    .rise_i     (sclk_rise),
    .sdi_i      (sdi_s),
    .commit_o   (commit),
    .word_o     (word),
    .bit_cnt_o  (bit_cnt)
  );

  sadc_regs #(.FW(FW), .AW(AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .commit_i   (commit),
    .word_i     (word),
    .ctrl_o     (ctrl_o),
    .test_o     (test_w),
    .cal_wr_o   (cal_wr_o),
    .cal_wdata_o(cal_wdata_o)
  );

  assign rd_sel_o = ctrl_o[RSEL_LSB +: 2];

  always_comb begin
    unique case (rd_sel_e'(rd_sel_o))
      RS_STAT: rd_word = status_i;
      RS_TEST: rd_word = {{AW{1'b0}}, test_w};
      RS_CAL:  rd_word = {{AW{1'b0}}, cal_data_i};
      default: rd_word = {{AW{1'b0}}, conv_data_i};
    endcase
  end

  sadc_tx #(.FW(FW)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (frame_start),
    .frame_act_i(frame_act),
    .fall_i     (sclk_fall),
    .load_i     (rd_word),
    .bit_o      (tx_bit)
  );

  assign sdo_oe_o = frame_act;
  assign sdo_o    = frame_act & tx_bit;
endmodule

// File: rtl/sadc_regport_chk.sv
module sadc_regport_chk #(
  parameter int unsigned FW = 16,
  parameter int unsigned DW = 14,
  parameter int unsigned CW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          frame_act,
  input logic          frame_start,
  input logic          sclk_fall,
  input logic          commit,
  input logic [FW-1:0] word,
  input logic [CW-1:0] bit_cnt,
  input logic [DW-1:0] ctrl_o,
  input logic [1:0]    rd_sel_o,
  input logic          cal_wr_o,
  input logic          sdo_o,
  input logic          sdo_oe_o
);
  p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= CW'(FW));

  p_partial_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_act |=> bit_cnt == '0);

  p_ctrl_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> $past(commit && word[FW-1 -: 2] == 2'b11));

  p_rsel_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rd_sel_o) |-> $past(commit && word[FW-1 -: 2] == 2'b11));

  p_cal_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_wr_o |-> $past(commit && word[FW-1 -: 2] == 2'b10));

  p_cal_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_wr_o |=> !cal_wr_o);

  p_tristate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o);

  p_sdo_edge_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o && $past(sdo_oe_o) && !$stable(sdo_o)) |-> $past(sclk_fall || frame_start));
endmodule

bind serial_adc_regport sadc_regport_chk #(.FW(FW), .DW(DW), .CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frame_act  (frame_act),
  .frame_start(frame_start),
  .sclk_fall  (sclk_fall),
  .commit     (commit),
  .word       (word),
  .bit_cnt    (bit_cnt),
  .ctrl_o     (ctrl_o),
  .rd_sel_o   (rd_sel_o),
  .cal_wr_o   (cal_wr_o),
  .sdo_o      (sdo_o),
  .sdo_oe_o   (sdo_oe_o)
);

// File: tb/sim_serial_adc_regport.sv
`timescale 1ns/1ps
module sim_serial_adc_regport;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [13:0] conv_data = 14'h2A5C;
  logic [15:0] status = 16'hBEEF;
  logic [13:0] cal_data = 14'h1E37;
  logic        sdo, sdo_oe, cal_wr;
  logic [13:0] ctrl, cal_wdata;
  logic [1:0]  rd_sel;

  int tests = 0, fails = 0, cal_cnt = 0, edge_bad = 0, oe_bad = 0;
  logic [13:0] last_cal = '0;
  logic [15:0] last_rd;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  event        done_ev;
  bit          finished = 0;

  always #10 clk = ~clk;

  serial_adc_regport u0 (
    .clk_i(clk), .rst_ni(rst_ni), .frame_n_i(frame_n), .sclk_i(sclk), .sdi_i(sdi),
    .conv_data_i(conv_data), .status_i(status), .cal_data_i(cal_data),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .ctrl_o(ctrl), .rd_sel_o(rd_sel),
    .cal_wr_o(cal_wr), .cal_wdata_o(cal_wdata)
  );

  always @(posedge clk) if (cal_wr) begin cal_cnt++; last_cal = cal_wdata; end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic [15:0] wr, input int nbits, output logic [15:0] rd);
    rd = '0;
    frame_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      logic pre;
      sdi = (i < 16) ? wr[15-i] : 1'b1;
      repeat (6) @(negedge clk);
      pre = sdo;
      if (!sdo_oe) oe_bad++;
      if (i < 16) rd[15-i] = sdo;
      sclk = 1'b1;
      repeat (6) @(negedge clk);
      if (sdo !== pre) edge_bad++;
      sclk = 1'b0;
    end
    repeat (6) @(negedge clk);
    frame_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] wr, input logic [15:0] exp, input string tag);
    logic [15:0] rd;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    run_frame(wr, 16, rd);
    last_rd = rd;
    -> done_ev;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(done_ev);
      chk(tag_q.pop_front(), {16'h0, last_rd}, {16'h0, exp_q.pop_front()});
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] rd;
    int cc;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 ctrl reset", ctrl, 0);
    chk("R4 rd_sel reset", rd_sel, 0);
    chk("R10 idle oe", sdo_oe, 0);
    chk("R10 idle sdo", sdo, 0);

    // R4 default read; R8 code 00 writes nothing
    xfer(16'h0000, {2'b00, 14'h2A5C}, "R4 conv read");
    chk("R8 nop no strobe", cal_cnt, 0);
    chk("R8 nop ctrl", ctrl, 0);

    // R12 control write: same frame still returns conversion data
    xfer({2'b11, 14'h00C5}, {2'b00, 14'h2A5C}, "R12 old source in ctrl frame");
    chk("R3 ctrl written", ctrl, 14'h00C5);
    chk("R1 rd_sel from bits 7:6", rd_sel, 2'b11);

    xfer(16'h0000, 16'hBEEF, "R5 status read");
    status = 16'h8001;
    xfer(16'h0000, 16'h8001, "R9 sticky status read");

    // R7 test word
    xfer({2'b01, 14'h1234}, 16'h8001, "R9 status during test write");
    chk("R7 test write leaves ctrl", ctrl, 14'h00C5);
    xfer({2'b11, 14'h0040}, 16'h8001, "R12 status during ctrl write");
    xfer(16'h0000, {2'b00, 14'h1234}, "R7 test read");

    // R8 calibration write
    cc = cal_cnt;
    xfer({2'b10, 14'h3ABC}, {2'b00, 14'h1234}, "R9 test read again");
    chk("R8 one cal strobe", cal_cnt - cc, 1);
    chk("R8 cal payload", last_cal, 14'h3ABC);
    chk("R8 cal keeps ctrl", ctrl, 14'h0040);

    xfer({2'b11, 14'h0080}, {2'b00, 14'h1234}, "R12 test during ctrl write");
    xfer(16'h0000, {2'b00, 14'h1E37}, "R6 cal read");

    // R2 partial frame
    run_frame({2'b11, 14'h3FFF}, 7, rd);
    chk("R2 partial ignored", ctrl, 14'h0080);
    xfer({2'b11, 14'h0000}, {2'b00, 14'h1E37}, "R2 full frame after partial");
    chk("R2 aligned decode", ctrl, 14'h0000);
    conv_data = 14'h3FFF;
    xfer(16'h0000, {2'b00, 14'h3FFF}, "R4 conv read full scale");

    // R11 extra edges
    cc = cal_cnt;
    run_frame({2'b11, 14'h00C3}, 20, rd);
    chk("R11 extra bits ignored", ctrl, 14'h00C3);
    chk("R11 no cal strobe", cal_cnt - cc, 0);
    chk("R1 data reach rd_sel", rd_sel, 2'b11);

    chk("R10 sdo stable across rising edges", edge_bad, 0);
    chk("R10 oe during frames", oe_bad, 0);
    chk("R10 idle oe after frames", sdo_oe, 0);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule